// File: doc/BRIEF.md
# Compare, Capture and PWM Channel

This block is a single channel that sits beside a shared counter. It does not count by itself. Each cycle it receives the counter value, a running flag and the overflow and underflow pulses. From these it either records when edges arrive on an input pin, or drives an output pin from comparisons against a programmable threshold.

The channel has four modes. In capture mode, selected edges on the raw input latch the counter value into a newest-capture register. The value that was there before moves into an older-capture register. An event output reports captures on every capture, on every second capture, or only on rising or only on falling edges.

In compare mode, the output pin reacts to a counter match, an overflow and an underflow, each with its own action. In edge-PWM mode, the pin is set when the counter wraps and cleared on a match. Outside these modes, and whenever the counter is stopped, the pin holds a programmable idle level. The threshold is loaded through a buffer that reaches the active register only at a wrap.

Top module: `cc_channel`

## Requirements
- R1: `cfg_mode` encodes 0 = off, 1 = capture, 2 = compare, 3 = PWM. After reset the captures, the active threshold and the internal pin level are 0. In off and capture modes the internal pin level takes `cfg_idle_lvl` at every clock.
- R2: `cfg_edge` encodes 0 = rising, 1 = falling, 2 = both, 3 = none. In capture mode, a qualifying change of `sig_in` that is present at one rising clock edge loads `cap_new` at the following clock edge. The value loaded is the `cnt_val` presented at that following edge.
- R3: On every capture, `cap_old` takes the previous value of `cap_new`. Without a capture, both registers hold.
- R4: `cfg_evsel` encodes 0 = every capture, 1 = every second capture (the second, fourth and so on since capture mode was entered), 2 = rising-edge captures only, 3 = falling-edge captures only. In capture mode, `evt_out` is a one-cycle pulse in the cycle after the qualifying capture.
- R5: Each action field (`cfg_act_match`, `cfg_act_ovf`, `cfg_act_unf`) encodes 0 = none, 1 = toggle, 2 = clear, 3 = set. In compare mode with the counter running, one action is applied per clock. Match (`cnt_val` equals `cmp_act`) has priority over overflow, and overflow has priority over underflow.
- R6: In compare and PWM modes, while `cnt_run` is 0, the internal pin level takes `cfg_idle_lvl`. Overflow, underflow and match are ignored. Counting resumes from that level.
- R7: `pin_out` is the internal pin level XOR `cfg_invert`.
- R8: In PWM mode with the counter running, a match clears the pin level. Otherwise an overflow or underflow sets it, and otherwise it holds. The action fields have no effect.
- R9: A write on `buf_wr` stores `buf_wdata` in the buffer and marks it full. On an overflow or underflow with the buffer full, `cmp_act` takes the buffered value at that edge and the mark clears. A write in the same cycle as such an update keeps the mark set with the new data. Without a full buffer, `cmp_act` holds.
- R10: In compare and PWM modes, `evt_out` follows `pin_out` when `cfg_evt_level` is 1. Otherwise it is a one-cycle pulse in the cycle after a running match. In off mode `evt_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 2 | Channel mode |
| cfg_edge | input | 2 | Capture edge select |
| cfg_evsel | input | 2 | Capture event select |
| cfg_act_match | input | 2 | Action on match |
| cfg_act_ovf | input | 2 | Action on overflow |
| cfg_act_unf | input | 2 | Action on underflow |
| cfg_idle_lvl | input | 1 | Pin level while stopped or unused |
| cfg_invert | input | 1 | Output polarity flip |
| cfg_evt_level | input | 1 | Event output follows pin instead of pulsing |
| buf_wr | input | 1 | Threshold buffer write strobe |
| buf_wdata | input | CNT_W | Threshold buffer write data |
| cnt_val | input | CNT_W | Shared counter value |
| cnt_ovf | input | 1 | Counter overflow pulse |
| cnt_unf | input | 1 | Counter underflow pulse |
| cnt_run | input | 1 | Counter running flag |
| sig_in | input | 1 | Raw capture input |
| pin_out | output | 1 | Channel output pin |
| evt_out | output | 1 | Event output |
| cap_new | output | CNT_W | Newest capture |
| cap_old | output | CNT_W | Capture before the newest |
| cmp_act | output | CNT_W | Active compare threshold |

## Verification
The assertions assume that every input is driven to a known value from the first clock after reset. They also assume that the configuration fields change only between clock edges. The bench holds each random configuration for a whole phase and changes inputs only at falling clock edges.

The bench derives `cnt_val` from its own counter, which runs up or down for a phase. It raises overflow only on the top value and underflow only on zero. So the wrap pulses, the buffer updates and the matches occur the way a real counter would produce them. Random input toggles, buffer writes and pauses of the running flag are mixed in.

// File: rtl/cc_pkg.sv
package cc_pkg;

    typedef enum logic [1:0] {
        MODE_OFF     = 2'd0,
        MODE_CAPTURE = 2'd1,
        MODE_COMPARE = 2'd2,
        MODE_PWM     = 2'd3
    } cc_mode_e;

    typedef enum logic [1:0] {
        EDGE_RISE = 2'd0,
        EDGE_FALL = 2'd1,
        EDGE_BOTH = 2'd2,
        EDGE_NONE = 2'd3
    } cc_edge_e;

    typedef enum logic [1:0] {
        EV_EVERY     = 2'd0,
        EV_SECOND    = 2'd1,
        EV_RISE_ONLY = 2'd2,
        EV_FALL_ONLY = 2'd3
    } cc_evsel_e;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'd0,
        ACT_TOGGLE = 2'd1,
        ACT_CLEAR  = 2'd2,
        ACT_SET    = 2'd3
    } cc_act_e;

    function automatic logic apply_action(cc_act_e act, logic cur);
        logic res;
        case (act)
            ACT_TOGGLE: res = ~cur;
            ACT_CLEAR:  res = 1'b0;
            ACT_SET:    res = 1'b1;
            default:    res = cur;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/cc_edge_detect.sv
module cc_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_in,
    output logic rise,
    output logic fall
);
    typedef struct packed {
        logic in_q;
        logic in_qq;
    } edge_state_t;

    edge_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.in_q  = sig_in;
        st_d.in_qq = st_q.in_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise = st_q.in_q & ~st_q.in_qq;
    assign fall = ~st_q.in_q & st_q.in_qq;

    // R2: a detected rising edge means the input was high one clock earlier
    assert_rise_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.in_q) |-> $past(sig_in));
endmodule

// File: rtl/cc_cmp_buffer.sv
module cc_cmp_buffer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             buf_wr,
    input  logic [CNT_W-1:0] buf_wdata,
    input  logic             upd,
    output logic [CNT_W-1:0] cmp_act
);
    typedef struct packed {
        logic [CNT_W-1:0] bufv;
        logic             full;
        logic [CNT_W-1:0] act;
    } buf_state_t;

    buf_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (upd && st_q.full) begin
            st_d.act  = st_q.bufv;
            st_d.full = 1'b0;
        end
        if (buf_wr) begin
            st_d.bufv = buf_wdata;
            st_d.full = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cmp_act = st_q.act;

    assert_act_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.full |=> $stable(cmp_act));
    assert_no_upd_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(cmp_act));
endmodule

// File: rtl/cc_capture.sv
module cc_capture
    import cc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cc_mode_e         mode,
    input  cc_edge_e         edge_sel,
    input  cc_evsel_e        ev_sel,
    input  logic             rise,
    input  logic             fall,
    input  logic [CNT_W-1:0] cnt_val,
    output logic [CNT_W-1:0] cap_new,
    output logic [CNT_W-1:0] cap_old,
    output logic             cap_evt
);
    typedef struct packed {
        logic [CNT_W-1:0] cnew;
        logic [CNT_W-1:0] cold;
        logic             parity;
        logic             evt;
    } cap_state_t;

    cap_state_t st_d, st_q;
    logic cap_mode, fire_r, fire_f, fire;

    always_comb begin
        cap_mode = (mode == MODE_CAPTURE);
        fire_r   = cap_mode && rise && (edge_sel == EDGE_RISE || edge_sel == EDGE_BOTH);
        fire_f   = cap_mode && fall && (edge_sel == EDGE_FALL || edge_sel == EDGE_BOTH);
        fire     = fire_r || fire_f;

        st_d = st_q;
        if (fire) begin
            st_d.cold = st_q.cnew;
            st_d.cnew = cnt_val;
        end
        if (!cap_mode)  st_d.parity = 1'b0;
        else if (fire)  st_d.parity = ~st_q.parity;

        case (ev_sel)
            EV_EVERY:     st_d.evt = fire;
            EV_SECOND:    st_d.evt = fire && st_q.parity;
            EV_RISE_ONLY: st_d.evt = fire_r;
            default:      st_d.evt = fire_f;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cap_new = st_q.cnew;
    assign cap_old = st_q.cold;
    assign cap_evt = st_q.evt;

    assert_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> cap_old == $past(cap_new));
    assert_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> cap_new == $past(cnt_val));
    assert_evt_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |-> $past(fire));
endmodule

// File: rtl/cc_out_ctrl.sv
module cc_out_ctrl
    import cc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cc_mode_e         mode,
    input  cc_act_e          act_match,
    input  cc_act_e          act_ovf,
    input  cc_act_e          act_unf,
    input  logic             idle_lvl,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic [CNT_W-1:0] cmp_act,
    input  logic             cnt_ovf,
    input  logic             cnt_unf,
    input  logic             cnt_run,
    output logic             out_lvl,
    output logic             match_evt
);
    typedef struct packed {
        logic lvl;
        logic mevt;
    } out_state_t;

    out_state_t st_d, st_q;
    logic match;

    always_comb begin
        match = cnt_run && (cnt_val == cmp_act);
        st_d  = st_q;
        st_d.mevt = 1'b0;
        case (mode)
            MODE_COMPARE: begin
                st_d.mevt = match;
                if (!cnt_run)     st_d.lvl = idle_lvl;
                else if (match)   st_d.lvl = apply_action(act_match, st_q.lvl);
                else if (cnt_ovf) st_d.lvl = apply_action(act_ovf, st_q.lvl);
                else if (cnt_unf) st_d.lvl = apply_action(act_unf, st_q.lvl);
            end
            MODE_PWM: begin
                st_d.mevt = match;
                if (!cnt_run)                st_d.lvl = idle_lvl;
                else if (match)              st_d.lvl = 1'b0;
                else if (cnt_ovf || cnt_unf) st_d.lvl = 1'b1;
            end
            default: st_d.lvl = idle_lvl;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_lvl   = st_q.lvl;
    assign match_evt = st_q.mevt;

    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == MODE_COMPARE || mode == MODE_PWM) && !cnt_run) |=> out_lvl == $past(idle_lvl));
    assert_pwm_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_PWM && match) |=> !out_lvl);
    assert_cmp_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_COMPARE && match && act_match == ACT_SET) |=> out_lvl);
    assert_off_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_OFF) |=> out_lvl == $past(idle_lvl));
endmodule

// File: rtl/cc_channel.sv
module cc_channel
    import cc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       cfg_mode,
    input  logic [1:0]       cfg_edge,
    input  logic [1:0]       cfg_evsel,
    input  logic [1:0]       cfg_act_match,
    input  logic [1:0]       cfg_act_ovf,
    input  logic [1:0]       cfg_act_unf,
    input  logic             cfg_idle_lvl,
    input  logic             cfg_invert,
    input  logic             cfg_evt_level,
    input  logic             buf_wr,
    input  logic [CNT_W-1:0] buf_wdata,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             cnt_ovf,
    input  logic             cnt_unf,
    input  logic             cnt_run,
    input  logic             sig_in,
    output logic             pin_out,
    output logic             evt_out,
    output logic [CNT_W-1:0] cap_new,
    output logic [CNT_W-1:0] cap_old,
    output logic [CNT_W-1:0] cmp_act
);
    cc_mode_e mode;
    logic rise, fall, cap_evt, out_lvl, match_evt, drive_mode;

    assign mode       = cc_mode_e'(cfg_mode);
    assign drive_mode = (mode == MODE_COMPARE) || (mode == MODE_PWM);

    cc_edge_detect u_edge (
        .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .rise(rise), .fall(fall)
    );

    cc_cmp_buffer #(.CNT_W(CNT_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .buf_wr(buf_wr), .buf_wdata(buf_wdata),
        .upd(cnt_ovf | cnt_unf), .cmp_act(cmp_act)
    );

    cc_capture #(.CNT_W(CNT_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .mode(mode),
        .edge_sel(cc_edge_e'(cfg_edge)), .ev_sel(cc_evsel_e'(cfg_evsel)),
        .rise(rise), .fall(fall), .cnt_val(cnt_val),
        .cap_new(cap_new), .cap_old(cap_old), .cap_evt(cap_evt)
    );

    cc_out_ctrl #(.CNT_W(CNT_W)) u_out (
        .clk(clk), .rst_n(rst_n), .mode(mode),
        .act_match(cc_act_e'(cfg_act_match)), .act_ovf(cc_act_e'(cfg_act_ovf)),
        .act_unf(cc_act_e'(cfg_act_unf)), .idle_lvl(cfg_idle_lvl),
        .cnt_val(cnt_val), .cmp_act(cmp_act), .cnt_ovf(cnt_ovf),
        .cnt_unf(cnt_unf), .cnt_run(cnt_run),
        .out_lvl(out_lvl), .match_evt(match_evt)
    );

    assign pin_out = out_lvl ^ cfg_invert;
    assign evt_out = (drive_mode && cfg_evt_level) ? pin_out : (cap_evt | match_evt);

    assert_off_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_OFF && $past(mode) == MODE_OFF) |-> !evt_out);
endmodule

// File: tb/test_cc_channel.sv
module test_cc_channel;
    localparam int CLK_PERIOD = 10;
    localparam int W = 8;
    localparam logic [W-1:0] TOP = '1;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [1:0] cfg_mode = '0, cfg_edge = '0, cfg_evsel = '0;
    logic [1:0] cfg_act_match = '0, cfg_act_ovf = '0, cfg_act_unf = '0;
    logic cfg_idle_lvl = 1'b0, cfg_invert = 1'b0, cfg_evt_level = 1'b0;
    logic buf_wr = 1'b0, cnt_ovf = 1'b0, cnt_unf = 1'b0, cnt_run = 1'b0, sig_in = 1'b0;
    logic [W-1:0] buf_wdata = '0, cnt_val = '0;
    logic pin_out, evt_out;
    logic [W-1:0] cap_new, cap_old, cmp_act;

    int n_vec = 0, n_bad = 0;

    // reference state
    logic m_inq = 0, m_inqq = 0, m_par = 0, m_cevt = 0, m_mevt = 0, m_lvl = 0, m_full = 0;
    logic [W-1:0] m_capn = '0, m_capo = '0, m_buf = '0, m_act = '0;
    logic [W-1:0] ctr = '0;
    logic dir_up = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    cc_channel #(.CNT_W(W)) i_cc_channel (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_edge(cfg_edge),
        .cfg_evsel(cfg_evsel), .cfg_act_match(cfg_act_match), .cfg_act_ovf(cfg_act_ovf),
        .cfg_act_unf(cfg_act_unf), .cfg_idle_lvl(cfg_idle_lvl), .cfg_invert(cfg_invert),
        .cfg_evt_level(cfg_evt_level), .buf_wr(buf_wr), .buf_wdata(buf_wdata),
        .cnt_val(cnt_val), .cnt_ovf(cnt_ovf), .cnt_unf(cnt_unf), .cnt_run(cnt_run),
        .sig_in(sig_in), .pin_out(pin_out), .evt_out(evt_out), .cap_new(cap_new),
        .cap_old(cap_old), .cmp_act(cmp_act)
    );

    function automatic logic act_fn(logic [1:0] a, logic cur);
        case (a)
            2'd1: return ~cur;
            2'd2: return 1'b0;
            2'd3: return 1'b1;
            default: return cur;
        endcase
    endfunction

    task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h (t=%0t mode=%0d)", tag, act, exp, $time, cfg_mode);
        end
    endtask

    // Advance the reference by one clock using the inputs now driven.
    task automatic model_step();
        logic rise, fall, capm, fr, ff, fire, match, upd;
        rise = m_inq & ~m_inqq;
        fall = ~m_inq & m_inqq;
        m_inqq = m_inq;
        m_inq = sig_in;
        capm = (cfg_mode == 2'd1);
        fr = capm && rise && (cfg_edge == 2'd0 || cfg_edge == 2'd2);
        ff = capm && fall && (cfg_edge == 2'd1 || cfg_edge == 2'd2);
        fire = fr || ff;
        case (cfg_evsel)
            2'd0: m_cevt = fire;
            2'd1: m_cevt = fire && m_par;
            2'd2: m_cevt = fr;
            default: m_cevt = ff;
        endcase
        if (fire) begin m_capo = m_capn; m_capn = cnt_val; end
        m_par = capm ? (fire ? ~m_par : m_par) : 1'b0;
        match = cnt_run && (cnt_val == m_act);
        m_mevt = (cfg_mode >= 2'd2) && match;
        if (cfg_mode == 2'd2) begin
            if (!cnt_run) m_lvl = cfg_idle_lvl;
            else if (match) m_lvl = act_fn(cfg_act_match, m_lvl);
            else if (cnt_ovf) m_lvl = act_fn(cfg_act_ovf, m_lvl);
            else if (cnt_unf) m_lvl = act_fn(cfg_act_unf, m_lvl);
        end else if (cfg_mode == 2'd3) begin
            if (!cnt_run) m_lvl = cfg_idle_lvl;
            else if (match) m_lvl = 1'b0;
            else if (cnt_ovf || cnt_unf) m_lvl = 1'b1;
        end else m_lvl = cfg_idle_lvl;
        upd = cnt_ovf | cnt_unf;
        if (upd && m_full) begin m_act = m_buf; m_full = 1'b0; end
        if (buf_wr) begin m_buf = buf_wdata; m_full = 1'b1; end
    endtask

    task automatic check_all();
        logic ep, ee;
        string ptag, etag;
        ep = m_lvl ^ cfg_invert;
        if (cfg_mode >= 2'd2 && cfg_evt_level) ee = ep;
        else ee = m_cevt | m_mevt;
        if (cfg_mode < 2'd2) ptag = "R1";
        else if (cfg_invert) ptag = "R7";
        else if (cfg_mode == 2'd3) ptag = "R8";
        else ptag = "R5_R6";
        etag = (cfg_mode >= 2'd2) ? "R10" : "R4";
        chk(ptag, {{(W-1){1'b0}}, pin_out}, {{(W-1){1'b0}}, ep});
        chk(etag, {{(W-1){1'b0}}, evt_out}, {{(W-1){1'b0}}, ee});
        chk("R2", cap_new, m_capn);
        chk("R3", cap_old, m_capo);
        chk("R9", cmp_act, m_act);
    endtask

    // Drive one cycle of inputs (at a falling edge), then step the reference.
    task automatic drive_cycle(logic run_req);
        cnt_run = run_req;
        cnt_val = ctr;
        cnt_ovf = run_req && dir_up && (ctr == TOP);
        cnt_unf = run_req && !dir_up && (ctr == '0);
        if (run_req) ctr = dir_up ? ctr + 1'b1 : ctr - 1'b1;
        if (($urandom % 4) == 0) sig_in = ~sig_in;
        buf_wr = (($urandom % 8) == 0);
        buf_wdata = W'($urandom);
        model_step();
        @(posedge clk);
        @(negedge clk);
        check_all();
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", cap_new, '0);
        chk("R1", cmp_act, '0);
        chk("R1", {{(W-1){1'b0}}, pin_out}, '0);
        rst_n = 1'b1;
        // directed: write threshold 5, update it at a wrap, then PWM (R8, R9)
        cfg_mode = 2'd3;
        buf_wr = 1'b1; buf_wdata = 8'd5; model_step();
        @(posedge clk); @(negedge clk); check_all();
        buf_wr = 1'b0;
        ctr = TOP; dir_up = 1'b1;
        for (int i = 0; i < 20; i++) drive_cycle(1'b1);
        // directed: stopped counter holds idle level, inverted (R6, R7)
        cfg_mode = 2'd2; cfg_idle_lvl = 1'b1; cfg_invert = 1'b1;
        for (int i = 0; i < 4; i++) drive_cycle(1'b0);
        // random phases
        for (int ph = 0; ph < 80; ph++) begin
            cfg_mode      = 2'($urandom);
            cfg_edge      = 2'($urandom);
            cfg_evsel     = 2'($urandom);
            cfg_act_match = 2'($urandom);
            cfg_act_ovf   = 2'($urandom);
            cfg_act_unf   = 2'($urandom);
            cfg_idle_lvl  = 1'($urandom);
            cfg_invert    = 1'($urandom);
            cfg_evt_level = 1'($urandom);
            dir_up        = 1'($urandom);
            for (int i = 0; i < 3; i++) drive_cycle(1'b0);
            for (int i = 0; i < 600; i++) drive_cycle(($urandom % 16) != 0);
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 190000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule